// File: doc/BRIEF.md
# Read-Address Unlock Sequence Detector

This block watches the ordinary access traffic of a 13-bit-address memory that has a shadow non-volatile copy of its array. Software starts a shadow transfer using only reads. Five fixed addresses must be read in a set order, and the sixth read then triggers the transfer. The sixth address selects the direction: 0x0F0F starts a STORE (working array into shadow), and 0x0F0E starts a RECALL (shadow into working array). Because only reads are used, no extra pin is needed.

An access ends either when select falls or when the address changes while select stays high. Only that completed access counts as a step, so the transient states of a skewing address bus never count. While a transfer runs, the block reports it on an activity output and blocks memory access for a fixed number of cycles. It also reports which of the two internal phases is running: clear/erase first, then copy/program. A digital supply-good input gates STORE. When the supply is low, a STORE is not started, and a STORE already running is abandoned. A RECALL always runs to completion. After reset, the first cycle in which the supply is good starts an automatic RECALL.

Top module: `nv_unlock_seq`

## Requirements
- R1: After reset, every output is 0. `mem_en` stays 0 until the power-up recall has finished.
- R2: The first clock edge after reset that samples `supply_ok`=1 starts a RECALL. `recall_active` is then high for exactly RECALL_CYC cycles, after which `mem_en` becomes 1.
- R3: An access completes at the edge where `sel` is sampled low, or where `addr` differs from its previous value with `sel` still high. The access counts as a write if `wr` was high in any of its selected cycles, and as a read otherwise.
- R4: Reads of 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and 0x0F0F, in that order, start a STORE on the edge that completes the sixth read. `store_active` is then high for exactly STORE_CYC cycles.
- R5: The same five reads followed by a read of 0x0F0E start a RECALL lasting RECALL_CYC cycles.
- R6: A read of any address other than the expected next one aborts the sequence. A read of 0x0000 makes 0x0000 the first step of a new sequence.
- R7: A completed write access aborts the sequence, whatever its address.
- R8: If `supply_ok` is 0 on the edge that completes a STORE sequence, no STORE starts and the sequence is cleared.
- R9: If `supply_ok` is sampled 0 while a STORE runs, `store_active` drops on that edge and `store_abort` is 1 for exactly one cycle.
- R10: A RECALL runs its full length whatever the value of `supply_ok`.
- R11: While a transfer runs, `mem_en` is 0 and accesses have no effect. Sequence tracking restarts empty once the transfer ends.
- R12: `nv_phase` is 0 during the first (length − length/2) cycles of a transfer (clear or erase) and 1 during the last length/2 cycles (copy or program). It is 0 when no transfer runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Chip select, active high |
| wr | input | 1 | Write strobe, active high |
| addr | input | 13 | Access address |
| supply_ok | input | 1 | Supply above the sense threshold |
| store_active | output | 1 | STORE transfer running |
| recall_active | output | 1 | RECALL transfer running |
| nv_phase | output | 1 | 0: clear/erase phase, 1: copy/program phase |
| mem_en | output | 1 | Array open to normal reads and writes |
| store_abort | output | 1 | One-cycle pulse when a STORE is abandoned |

## Verification
Assertions check the following on every cycle:
- the two transfer kinds never overlap;
- the array is never open during a transfer;
- a STORE never begins without a good supply;
- a low supply ends a STORE with an abort pulse at once;
- a RECALL is never cut short;
- the step counter stays in range.

Some behaviour only the bench scenarios can show:
- which address orders unlock a transfer, and that a write or a stray address breaks the key;
- that 0x0000 restarts the key;
- that held-select bursts count like separate strobes;
- that traffic during a transfer is discarded.

For these, a behavioural model compares every output on every clock.

// File: rtl/nv_unlock_seq.sv
`timescale 1ns/1ps
module nv_unlock_seq #(
  parameter int STORE_CYC  = 40,
  parameter int RECALL_CYC = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel,
  input  logic        wr,
  input  logic [12:0] addr,
  input  logic        supply_ok,
  output logic        store_active,
  output logic        recall_active,
  output logic        nv_phase,
  output logic        mem_en,
  output logic        store_abort
);
  localparam int MAXC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [12:0] LAST_STORE  = 13'h0F0F;
  localparam logic [12:0] LAST_RECALL = 13'h0F0E;

  typedef enum logic [1:0] {OP_IDLE, OP_STORE, OP_RECALL} op_t;

  op_t         op;
  logic [CW-1:0] cnt;
  logic        pwr_done;
  logic        s_q, w_acc;
  logic [12:0] a_q;
  logic [2:0]  step, step_nx;

  function automatic logic [12:0] key_at(input logic [2:0] i);
    case (i)
      3'd0: key_at = 13'h0000;
      3'd1: key_at = 13'h1555;
      3'd2: key_at = 13'h0AAA;
      3'd3: key_at = 13'h1FFF;
      default: key_at = 13'h10F0;
    endcase
  endfunction

  wire idle       = (op == OP_IDLE);
  wire track      = pwr_done && idle;
  wire done_acc   = s_q && (!sel || addr != a_q);
  wire rd_done    = done_acc && !w_acc;
  wire hit_store  = rd_done && step == 3'd5 && a_q == LAST_STORE;
  wire hit_recall = rd_done && step == 3'd5 && a_q == LAST_RECALL;

  always_comb begin
    step_nx = step;
    if (done_acc) begin
      if (w_acc)                                step_nx = 3'd0;
      else if (step < 3'd5 && a_q == key_at(step)) step_nx = step + 3'd1;
      else if (a_q == 13'h0000)                 step_nx = 3'd1;
      else                                      step_nx = 3'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op          <= OP_IDLE;
      cnt         <= '0;
      pwr_done    <= 1'b0;
      store_abort <= 1'b0;
      s_q         <= 1'b0;
      w_acc       <= 1'b0;
      a_q         <= '0;
      step        <= '0;
    end else begin
      store_abort <= 1'b0;
      if (!pwr_done) begin
        if (supply_ok) begin
          op       <= OP_RECALL;
          cnt      <= CW'(RECALL_CYC - 1);
          pwr_done <= 1'b1;
        end
      end else if (!idle) begin
        if (op == OP_STORE && !supply_ok) begin
          op          <= OP_IDLE;
          store_abort <= 1'b1;
        end else if (cnt == '0) begin
          op <= OP_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (hit_store && supply_ok) begin
        op  <= OP_STORE;
        cnt <= CW'(STORE_CYC - 1);
      end else if (hit_recall) begin
        op  <= OP_RECALL;
        cnt <= CW'(RECALL_CYC - 1);
      end

      if (!track) begin
        s_q   <= 1'b0;
        w_acc <= 1'b0;
        step  <= '0;
      end else begin
        s_q   <= sel;
        a_q   <= addr;
        w_acc <= done_acc ? (sel & wr) : (w_acc | (sel & wr));
        step  <= step_nx;
      end
    end
  end

  assign store_active  = (op == OP_STORE);
  assign recall_active = (op == OP_RECALL);
  assign mem_en        = track;
  assign nv_phase      = store_active  ? (cnt < CW'(STORE_CYC / 2)) :
                         recall_active ? (cnt < CW'(RECALL_CYC / 2)) : 1'b0;

  assert_one_op_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({store_active, recall_active}));
  assert_closed_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> !store_active && !recall_active);
  assert_store_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(store_active) |-> $past(supply_ok));
  assert_store_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    store_active && !supply_ok |=> !store_active && store_abort);
  assert_recall_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    recall_active && cnt != '0 |=> recall_active);
  assert_step_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step <= 3'd5);
  assert_no_phase_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !store_active && !recall_active |-> !nv_phase);
endmodule

// File: tb/nv_unlock_seq_tb.sv
`timescale 1ns/1ps
module nv_unlock_seq_tb;
  localparam int SC = 40;
  localparam int RC = 12;

  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst_n = 0, sel = 0, wr = 0, supply_ok = 0;
  logic [12:0] addr = '0;
  logic store_active, recall_active, nv_phase, mem_en, store_abort;

  nv_unlock_seq #(.STORE_CYC(SC), .RECALL_CYC(RC)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr),
    .supply_ok(supply_ok), .store_active(store_active),
    .recall_active(recall_active), .nv_phase(nv_phase),
    .mem_en(mem_en), .store_abort(store_abort));

  int checks = 0, failures = 0;
  string cur_req = "R1";

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  int key_tbl[5] = '{'h0000, 'h1555, 'h0AAA, 'h1FFF, 'h10F0};
  int m_op = 0, m_left = 0, m_idx = 0, m_prev_addr = 0;
  bit m_pwr = 0, m_prev_sel = 0, m_wrote = 0, m_abort = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_op = 0; m_left = 0; m_idx = 0; m_pwr = 0; m_prev_sel = 0;
      m_wrote = 0; m_abort = 0; m_prev_addr = 0;
    end else begin
      bit fin, rd, st, rc, on;
      int nidx;
      on  = m_pwr && m_op == 0;
      fin = m_prev_sel && (!sel || int'(addr) != m_prev_addr);
      rd  = fin && !m_wrote;
      nidx = m_idx;
      if (fin) begin
        if (!rd) nidx = 0;
        else if (m_idx < 5 && m_prev_addr == key_tbl[m_idx]) nidx = m_idx + 1;
        else if (m_prev_addr == 0) nidx = 1;
        else nidx = 0;
      end
      st = rd && m_idx == 5 && m_prev_addr == 'h0F0F;
      rc = rd && m_idx == 5 && m_prev_addr == 'h0F0E;
      m_abort = 0;
      if (!m_pwr) begin
        if (supply_ok) begin m_op = 2; m_left = RC; m_pwr = 1; end
      end else if (m_op != 0) begin
        if (m_op == 1 && !supply_ok) begin m_op = 0; m_abort = 1; end
        else begin m_left--; if (m_left == 0) m_op = 0; end
      end else if (st && supply_ok) begin m_op = 1; m_left = SC; end
      else if (rc) begin m_op = 2; m_left = RC; end
      if (!on) begin m_prev_sel = 0; m_wrote = 0; m_idx = 0; end
      else begin
        m_wrote = fin ? (sel && wr) : (m_wrote || (sel && wr));
        m_prev_sel = sel; m_prev_addr = int'(addr); m_idx = nidx;
      end
    end
  end

  always @(negedge clk) begin
    int exp_v, act_v, len;
    len = (m_op == 1) ? SC : RC;
    exp_v = {m_op == 1, m_op == 2, (m_op != 0) && (m_left <= len / 2),
             m_pwr && m_op == 0, m_abort};
    act_v = {store_active, recall_active, nv_phase, mem_en, store_abort};
    chk({cur_req, " per-cycle"}, act_v, exp_v);
  end

  task automatic rd_acc(input logic [12:0] a);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    @(negedge clk); sel = 0;
  endtask

  task automatic wr_acc(input logic [12:0] a);
    @(negedge clk); sel = 1; wr = 1; addr = a;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic burst(input int q[$]);
    @(negedge clk); sel = 1; wr = 0;
    foreach (q[i]) begin addr = 13'(q[i]); @(negedge clk); end
    sel = 0;
  endtask

  task automatic prefix();
    foreach (key_tbl[i]) rd_acc(13'(key_tbl[i]));
  endtask

  task automatic wait_open();
    while (!mem_en) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n, z;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {store_active, recall_active, nv_phase, mem_en, store_abort}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 closed before supply", mem_en, 0);

    cur_req = "R2";
    supply_ok = 1;
    @(negedge clk);
    chk("R2 power-up recall", recall_active, 1);
    n = 0;
    while (recall_active) begin n++; @(negedge clk); end
    chk("R2 recall length", n, RC);
    chk("R2 open after recall", mem_en, 1);

    cur_req = "R4";
    prefix(); rd_acc(13'h0F0F);
    @(negedge clk);
    chk("R4 store starts", store_active, 1);
    n = 0; z = 0;
    while (store_active) begin n++; if (!nv_phase) z++; @(negedge clk); end
    chk("R4 store length", n, SC);
    chk("R12 erase phase cycles", z, SC - SC / 2);

    cur_req = "R5 R3";
    burst('{'h0000, 'h1555, 'h0AAA, 'h1FFF, 'h10F0, 'h0F0E});
    @(negedge clk);
    chk("R5 R3 burst recall", recall_active, 1);
    wait_open();

    cur_req = "R6";
    rd_acc(13'h0000); rd_acc(13'h1555); rd_acc(13'h0123);
    rd_acc(13'h0AAA); rd_acc(13'h1FFF); rd_acc(13'h10F0); rd_acc(13'h0F0F);
    repeat (2) @(negedge clk);
    chk("R6 wrong address aborts", store_active, 0);
    rd_acc(13'h0000); rd_acc(13'h1555); rd_acc(13'h0000);
    rd_acc(13'h1555); rd_acc(13'h0AAA); rd_acc(13'h1FFF); rd_acc(13'h10F0);
    rd_acc(13'h0F0F);
    @(negedge clk);
    chk("R6 restart on 0000", store_active, 1);
    wait_open();

    cur_req = "R7";
    rd_acc(13'h0000); rd_acc(13'h1555); wr_acc(13'h0AAA);
    rd_acc(13'h1FFF); rd_acc(13'h10F0); rd_acc(13'h0F0E);
    repeat (2) @(negedge clk);
    chk("R7 write mid-key", recall_active, 0);
    prefix(); wr_acc(13'h0F0F);
    repeat (2) @(negedge clk);
    chk("R7 write as last step", store_active, 0);

    cur_req = "R8";
    prefix();
    @(negedge clk); supply_ok = 0; sel = 1; addr = 13'h0F0F;
    @(negedge clk); sel = 0;
    @(negedge clk);
    chk("R8 no store on low supply", store_active, 0);
    supply_ok = 1;
    rd_acc(13'h0F0F);
    @(negedge clk);
    chk("R8 sequence cleared", store_active, 0);

    cur_req = "R9";
    prefix(); rd_acc(13'h0F0F);
    repeat (5) @(negedge clk);
    supply_ok = 0;
    @(negedge clk);
    chk("R9 store dropped", store_active, 0);
    chk("R9 abort pulse", store_abort, 1);
    @(negedge clk);
    chk("R9 pulse one cycle", store_abort, 0);
    supply_ok = 1;

    cur_req = "R10";
    prefix(); rd_acc(13'h0F0E);
    supply_ok = 0;
    @(negedge clk);
    n = 0;
    while (recall_active) begin n++; @(negedge clk); end
    chk("R10 recall full length on low supply", n, RC);
    supply_ok = 1;

    cur_req = "R11";
    prefix(); rd_acc(13'h0F0F);
    @(negedge clk);
    chk("R11 closed while busy", mem_en, 0);
    burst('{'h0000, 'h1555, 'h0AAA, 'h1FFF, 'h10F0, 'h0F0E});
    wait_open();
    repeat (3) @(negedge clk);
    chk("R11 busy traffic discarded", recall_active, 0);
    rd_acc(13'h0F0E);
    @(negedge clk);
    chk("R11 tracker empty after busy", recall_active, 0);

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule